// File: doc/BRIEF.md
# Bit-Configurable GPIO Port with Change Interrupt

This block is the register side of an 8-bit general-purpose I/O port. A bus interface in front of it issues one-cycle write and read strobes with a 2-bit register select. The block keeps an output latch, a per-bit read inversion mask and a per-bit direction mask. It drives an output enable and an output data bit for each pad, and it takes the raw pad levels through a two-flop synchronizer.

Pin levels are always visible through the input register, whatever each pin's direction is. Each bit of the read data is XORed with the inversion mask. When the input register is read, the block takes a snapshot of the synchronized pin levels before inversion. While any pin set as an input differs from that snapshot, the active-low interrupt is held low. The interrupt releases when the pins return to their snapshot values, or when the next input read takes a fresh snapshot.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the output latch reads 0xFF, the inversion mask reads 0x00 and the direction mask reads 0xFF. Every `pin_oe` and `pin_do` bit is 0, `irq_n` is 1 and `rd_data` is 0x00. The snapshot resets to all ones.
- R2: A direction bit of 1 makes its pin an input: `pin_oe` is 0 and `pin_do` is 0 for that bit. A direction bit of 0 makes `pin_oe` 1 and drives `pin_do` from the matching output latch bit. Both outputs follow the register one cycle after the write strobe.
- R3: A read strobe with select 0 (input register) places the synchronized pin levels XOR the inversion mask on `rd_data` one cycle later. This holds for every pin, input or output. A pin change reaches the synchronized value after two clock edges.
- R4: Select 1 (output latch) reads back the stored latch value, not the pad level.
- R5: A write strobe with select 0 changes nothing. The output latch, inversion mask, direction mask, `pin_oe` and `pin_do` all stay as they were.
- R6: `irq_n` is 0 while any input-direction pin differs from the snapshot. Pins set as outputs never affect it.
- R7: `irq_n` returns to 1 without a read once every differing input pin is back at its snapshot value.
- R8: Each input-register read strobe loads the snapshot with the synchronized pin levels before inversion. An interrupt pending before the strobe is therefore clear in the next cycle.
- R9: A pin turned from output to input by a direction write raises `irq_n` low in the next cycle when its level differs from the snapshot. The block does not mask this.
- R10: `rd_data` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Raw pad levels, asynchronous to `clk` |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| reg_sel | input | 2 | Register select: 0 input, 1 output latch, 2 inversion mask, 3 direction |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_oe | output | 8 | Per-pin output enable, 1 drives the pad |
| pin_do | output | 8 | Per-pin output level |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
Snapshot reload and change detection can fall in the same cycle. An input read re-arms the comparison, while pin transitions and direction writes move the live value it compares against. The bench provokes this in three ways: it reads the input register while a pin is away from the snapshot, it lets pins return without a read, and it turns an output pin into an input after that pin has moved. In each case it judges `irq_n` in the cycle after the strobe or after the synchronizer delay. Reading while the inversion mask is set shows whether the snapshot holds raw or inverted levels.

// File: rtl/gpio_pkg.sv
// Package: shared register select encoding for the GPIO port bank.
// The select values are decoded by the bus interface, so their order is fixed.
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_DIR = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Brings an asynchronous pin vector into the clock domain through a chain of
// STAGES flops. Assumes STAGES >= 2. Reset loads RST_VAL (the pull-up level).
module gpio_sync #(
    parameter int          WIDTH   = 8,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the output latch, read-inversion mask and direction mask, and drives
// per-pin output enable and data. Writes with the input-register select are
// discarded. Assumes single-cycle write strobes.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_do
);
    // Update the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            case (sel)
                SEL_OUT: out_q <= wr_data;
                SEL_POL: pol_q <= wr_data;
                SEL_DIR: dir_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Drive enables for output pins and gate data on input pins.
    always_comb begin
        pin_oe = ~dir_q;
        pin_do = out_q & ~dir_q;
    end

    // R2
    dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> (pin_oe == ~$past(wr_data)));

    // R5
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_change_det.sv
// Module: gpio_change_det
// Keeps a snapshot of the synchronized pin levels, reloaded on each input read,
// and pulls the active-low interrupt while any input pin differs from it.
// Assumes the pins are already synchronized and not inverted.
module gpio_change_det #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] dir_q,
    output logic             irq_n
);
    logic [WIDTH-1:0] snap_q;
    logic [WIDTH-1:0] diff;

    // Capture raw pin levels on each input-register read.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_q <= '1;
        else if (cap_en) snap_q <= pin_s;
    end

    // Flag input pins that no longer match the snapshot.
    always_comb begin
        diff  = (pin_s ^ snap_q) & dir_q;
        irq_n = ~|diff;
    end

    // R8
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (snap_q == $past(pin_s)));

    // R7
    irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cap_en) && $stable(pin_s) && $stable(dir_q)) |-> $stable(irq_n));
endmodule

// File: rtl/gpio_port_bank.sv
// Module: gpio_port_bank
// Top of the GPIO port: synchronizer, register bank, change detector and the
// registered read path. Assumes strobes last one cycle and come from a bus
// interface in the same clock domain.
module gpio_port_bank
    import gpio_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       reg_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_do,
    output logic             irq_n
);
    localparam logic [WIDTH-1:0] PULL_LVL = '1;

    reg_sel_e         sel;
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] dir_q;
    logic             rd_in;

    assign sel   = reg_sel_e'(reg_sel);
    assign rd_in = rd_en && (sel == SEL_IN);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH), .RST_VAL(PULL_LVL)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .dir_q   (dir_q),
        .pin_oe  (pin_oe),
        .pin_do  (pin_do)
    );

    gpio_change_det #(.WIDTH(WIDTH)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (rd_in),
        .pin_s  (pin_s),
        .dir_q  (dir_q),
        .irq_n  (irq_n)
    );

    // Register the selected value on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_IN:  rd_data <= pin_s ^ pol_q;
                SEL_OUT: rd_data <= out_q;
                SEL_POL: rd_data <= pol_q;
                SEL_DIR: rd_data <= dir_q;
                default: rd_data <= '0;
            endcase
        end
    end

    // R3
    in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_in |=> (rd_data == $past(pin_s ^ pol_q)));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R6
    out_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n) |-> (dir_q != '0));
endmodule

// File: tb/tb_gpio_port_bank.sv
`timescale 1ns/100ps
module tb_gpio_port_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'hFF;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, pin_oe, pin_do;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_port_bank dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .pin_oe(pin_oe), .pin_do(pin_do), .irq_n(irq_n)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [1:0] sel, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_i = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 oe", pin_oe, 8'h00);
        check("R1 do", pin_do, 8'h00);
        check("R1 irq", {7'd0, irq_n}, 8'h01);
        check("R1 rd_data", rd_data, 8'h00);
        do_read("R1 out", 2'd1, 8'hFF);
        do_read("R1 pol", 2'd2, 8'h00);
        do_read("R1 dir", 2'd3, 8'hFF);
    endtask

    task automatic t_direction;
        do_write(2'd1, 8'hA5);
        do_write(2'd3, 8'h0F);
        check("R2 oe", pin_oe, 8'hF0);
        check("R2 do", pin_do, 8'hA0);
        set_pins(8'h3C);
        do_read("R4 out latch", 2'd1, 8'hA5);
    endtask

    task automatic t_input_read;
        do_read("R3 raw", 2'd0, 8'h3C);
        do_write(2'd2, 8'h0F);
        do_read("R3 inverted", 2'd0, 8'h33);
    endtask

    task automatic t_ignore;
        do_write(2'd0, 8'h00);
        check("R5 oe", pin_oe, 8'hF0);
        check("R5 do", pin_do, 8'hA0);
        do_read("R5 out", 2'd1, 8'hA5);
        do_read("R5 pol", 2'd2, 8'h0F);
        do_read("R5 dir", 2'd3, 8'h0F);
    endtask

    task automatic t_irq;
        do_write(2'd3, 8'hFF);
        do_read("R8 read", 2'd0, 8'h33);
        check("R8 irq after read", {7'd0, irq_n}, 8'h01);
        set_pins(8'h38);
        check("R6 irq on change", {7'd0, irq_n}, 8'h00);
        set_pins(8'h3C);
        check("R7 irq self clear", {7'd0, irq_n}, 8'h01);
        set_pins(8'h38);
        check("R6 irq again", {7'd0, irq_n}, 8'h00);
        do_read("R8 read2", 2'd0, 8'h37);
        check("R8 raw snapshot clears", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_outpin;
        do_write(2'd3, 8'hFE);
        set_pins(8'h39);
        check("R6 output pin ignored", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_turnaround;
        do_write(2'd3, 8'hFF);
        check("R9 turnaround irq", {7'd0, irq_n}, 8'h00);
        do_read("R8 read3", 2'd0, 8'h36);
        check("R8 clear after turnaround", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_hold;
        do_read("R10 read", 2'd1, 8'hA5);
        set_pins(8'h00);
        repeat (3) @(negedge clk);
        check("R10 hold", rd_data, 8'hA5);
        check("R6 all changed", {7'd0, irq_n}, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_input_read();
        t_ignore();
        t_irq();
        t_outpin();
        t_turnaround();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule